// File: doc/BRIEF.md
# Audio Zero Detector and Soft Mute

This block sits in the output sample path of a stereo audio converter, running on the serial bit clock. It receives each deserialized left/right sample pair with a one-cycle valid strobe. It watches that stream for silence and, once the data has stayed at zero for a long run of bit clocks, it pulls a zero flag low. The flag is modelled as the enable of an open-drain pull-down, so several such flags can share one wired-OR line.

The same block applies a soft mute requested by an active-low level input. It does not cut the output at once. It scales every accepted sample by a gain that moves one step per sample: down towards zero while mute is requested, and back up towards unity once the request is withdrawn. Both controls are plain static levels; there is no register interface.

Top module: `audio_zero_mute`

## Requirements
- R1: While `rstN` is low and on its release, `zeroPullN` is 1 (pull-down off), `outValid` is 0, `outLeft`/`outRight` are 0, and the mute gain is at unity (RAMP_STEPS).
- R2: After reset, the data counts as zero from the first accepted pair whose two channels are both zero. Each rising bit-clock edge on which the data is zero adds one to a run counter. `zeroPullN` goes to 0 on the edge where the run reaches ZERO_LIMIT (default 65536) and stays 1 at ZERO_LIMIT-1.
- R3: A valid pair with a non-zero value on either channel clears the run counter and sets `zeroPullN` back to 1 on the edge at which the pair is accepted.
- R4: The run counter saturates at ZERO_LIMIT. `zeroPullN` stays 0 for as long as the data stays zero and never releases by wrap-around.
- R5: With `muteN` high and the gain at unity, each output equals its input sample unchanged.
- R6: Each valid pair accepted while `muteN` is 0 lowers the gain by one step, down to a floor of 0. Each output channel is floor(sample * gain / RAMP_STEPS), using the gain after the step. The output reaches 0 on the RAMP_STEPS-th muted pair and stays at 0.
- R7: Each valid pair accepted while `muteN` is 1 raises the gain by one step, up to RAMP_STEPS, with the same scaling as R6.
- R8: The gain changes only when a valid pair is accepted. Holding `muteN` at a level with no valid pairs does not move it.
- R9: Reset clears the run counter. After reset, a full ZERO_LIMIT run of zero data is needed again before `zeroPullN` goes to 0.
- R10: `outValid` is high for exactly the one cycle after each cycle in which `sampleValid` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe marking a new sample pair |
| sampleLeft | input | SAMPLE_W | Left sample, two's complement |
| sampleRight | input | SAMPLE_W | Right sample, two's complement |
| muteN | input | 1 | Mute request, 0 = mute, 1 = normal |
| zeroPullN | output | 1 | Pull-down enable of the zero flag, 0 = silence detected |
| outValid | output | 1 | Strobe for the scaled output pair |
| outLeft | output | SAMPLE_W | Scaled left sample |
| outRight | output | SAMPLE_W | Scaled right sample |

## Verification
The scaled pair and its strobe are registered once, so they are due on the first rising edge after the valid strobe. The bench drives each pair at a falling edge and reads the outputs at the next falling edge. The zero flag moves on the edge where the run counter reaches its limit, or on the edge where a non-zero pair is accepted. The bench therefore counts falling edges from the edge that took the first zero pair, and checks the flag still released at ZERO_LIMIT-1 edges and pulled low at ZERO_LIMIT. Gain steps are predicted one per accepted pair, and a long idle stretch checks that a changed mute level alone does not move them.

// File: rtl/azm_pkg.sv
package azm_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic load;      // capture and scale the presented pair
    logic gainDown;  // step the mute gain towards zero
    logic gainUp;    // step the mute gain towards unity
  } azm_strobe_t;

endpackage

// File: rtl/azm_ctrl.sv
module azm_ctrl
  import azm_pkg::*;
#(
  parameter int ZERO_LIMIT = 65536
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        sampleZero,
  input  logic        muteN,
  input  logic        gainAtMin,
  input  logic        gainAtMax,
  output azm_strobe_t strobes,
  output logic        zeroPullN
);

  localparam int CNT_W = $clog2(ZERO_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ZERO_LIMIT);

  logic             dataZero;
  logic             curZero;
  logic             hitNonZero;
  logic [CNT_W-1:0] runCount;

  assign hitNonZero = sampleValid && !sampleZero;
  assign curZero    = sampleValid ? sampleZero : dataZero;

  // Remember whether the most recent pair was silent
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataZero <= 1'b0;
    end else if (sampleValid) begin
      dataZero <= sampleZero;
    end
  end

  // Saturating run counter of silent bit clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
    end else if (hitNonZero) begin
      runCount <= '0;
    end else if (curZero && (runCount != CNT_TOP)) begin
      runCount <= runCount + 1'b1;
    end
  end

  assign zeroPullN = (runCount != CNT_TOP);

  always_comb begin
    strobes.load     = sampleValid;
    strobes.gainDown = sampleValid && !muteN && !gainAtMin;
    strobes.gainUp   = sampleValid &&  muteN && !gainAtMax;
  end

  // R2
  flag_onset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(zeroPullN) |-> ($past(runCount) == CNT_TOP - 1'b1));

  // R3
  nonzero_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitNonZero |=> (runCount == '0) && zeroPullN);

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runCount == CNT_TOP) && !hitNonZero |=> (runCount == CNT_TOP));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCount <= CNT_TOP);

endmodule

// File: rtl/azm_datapath.sv
module azm_datapath
  import azm_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int RAMP_STEPS = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  azm_strobe_t                strobes,
  input  logic signed [SAMPLE_W-1:0] sampleLeft,
  input  logic signed [SAMPLE_W-1:0] sampleRight,
  output logic                       sampleZero,
  output logic                       gainAtMin,
  output logic                       gainAtMax,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] outLeft,
  output logic signed [SAMPLE_W-1:0] outRight
);

  localparam int SHIFT  = $clog2(RAMP_STEPS);
  localparam int GAIN_W = SHIFT + 1;
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_TOP = GAIN_W'(RAMP_STEPS);

  logic [GAIN_W-1:0]        gain;
  logic [GAIN_W-1:0]        gainNext;
  logic signed [GAIN_W:0]   gainSigned;
  logic signed [PROD_W-1:0] prodLeft;
  logic signed [PROD_W-1:0] prodRight;
  logic signed [PROD_W-1:0] shiftLeft;
  logic signed [PROD_W-1:0] shiftRight;

  assign sampleZero = (sampleLeft == '0) && (sampleRight == '0);
  assign gainAtMin  = (gain == '0);
  assign gainAtMax  = (gain == GAIN_TOP);

  always_comb begin
    gainNext = gain;
    if (strobes.gainDown) begin
      gainNext = gain - 1'b1;
    end else if (strobes.gainUp) begin
      gainNext = gain + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gain <= GAIN_TOP;
    end else begin
      gain <= gainNext;
    end
  end

  // Scale both channels by the stepped gain, rounding towards minus infinity
  assign gainSigned = $signed({1'b0, gainNext});
  assign prodLeft   = PROD_W'(sampleLeft) * PROD_W'(gainSigned);
  assign prodRight  = PROD_W'(sampleRight) * PROD_W'(gainSigned);
  assign shiftLeft  = prodLeft >>> SHIFT;
  assign shiftRight = prodRight >>> SHIFT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLeft  <= '0;
      outRight <= '0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        outLeft  <= shiftLeft[SAMPLE_W-1:0];
        outRight <= shiftRight[SAMPLE_W-1:0];
      end
    end
  end

  // R6
  gain_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.gainDown |=> (gain + 1'b1 == $past(gain)));

  // R7
  gain_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.gainUp |=> (gain == $past(gain) + 1'b1));

  // R8
  gain_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(gain));

  // R6
  gain_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    gain <= GAIN_TOP);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> outValid);

  // R10
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> !outValid);

endmodule

// File: rtl/audio_zero_mute.sv
module audio_zero_mute
  import azm_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int ZERO_LIMIT = 65536,
  parameter int RAMP_STEPS = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleLeft,
  input  logic signed [SAMPLE_W-1:0] sampleRight,
  input  logic                       muteN,
  output logic                       zeroPullN,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] outLeft,
  output logic signed [SAMPLE_W-1:0] outRight
);

  azm_strobe_t strobes;
  logic        sampleZero;
  logic        gainAtMin;
  logic        gainAtMax;

  azm_ctrl #(
    .ZERO_LIMIT(ZERO_LIMIT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleZero (sampleZero),
    .muteN      (muteN),
    .gainAtMin  (gainAtMin),
    .gainAtMax  (gainAtMax),
    .strobes    (strobes),
    .zeroPullN  (zeroPullN)
  );

  azm_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .RAMP_STEPS(RAMP_STEPS)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .sampleLeft (sampleLeft),
    .sampleRight(sampleRight),
    .sampleZero (sampleZero),
    .gainAtMin  (gainAtMin),
    .gainAtMax  (gainAtMax),
    .outValid   (outValid),
    .outLeft    (outLeft),
    .outRight   (outRight)
  );

endmodule

// File: tb/audio_zero_mute_bench.sv
`timescale 1ns/1ps
module audio_zero_mute_bench;

  localparam int W     = 24;
  localparam int LIMIT = 65536;
  localparam int STEPS = 16;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                sampleValid = 1'b0;
  logic signed [W-1:0] sampleLeft = '0;
  logic signed [W-1:0] sampleRight = '0;
  logic                muteN = 1'b1;
  logic                zeroPullN;
  logic                outValid;
  logic signed [W-1:0] outLeft;
  logic signed [W-1:0] outRight;

  int checks = 0;
  int fails  = 0;
  int expGain = STEPS;

  always #2.5 clk = ~clk;

  audio_zero_mute #(
    .SAMPLE_W(W), .ZERO_LIMIT(LIMIT), .RAMP_STEPS(STEPS)
  ) u_audio_zero_mute (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight), .muteN(muteN),
    .zeroPullN(zeroPullN), .outValid(outValid),
    .outLeft(outLeft), .outRight(outRight)
  );

  typedef struct packed {
    logic                m;
    logic signed [W-1:0] l;
    logic signed [W-1:0] r;
    logic signed [W-1:0] el;
    logic signed [W-1:0] er;
  } vec_t;

  // Gain starts at 16; each entry steps it once (R5, R6, R7)
  localparam vec_t VECS [9] = '{
    '{1'b1, 24'sd1000, -24'sd1000, 24'sd1000, -24'sd1000},
    '{1'b1, 24'sh7FFFFF, 24'sh800000, 24'sh7FFFFF, 24'sh800000},
    '{1'b0, 24'sd1600, -24'sd1600, 24'sd1500, -24'sd1500},
    '{1'b0, 24'sd1600, -24'sd1601, 24'sd1400, -24'sd1401},
    '{1'b0, 24'sd160, 24'sd16, 24'sd130, 24'sd13},
    '{1'b1, 24'sd160, 24'sd16, 24'sd140, 24'sd14},
    '{1'b1, 24'sd160, -24'sd16, 24'sd150, -24'sd15},
    '{1'b1, 24'sd160, -24'sd16, 24'sd160, -24'sd16},
    '{1'b1, 24'sd7, -24'sd7, 24'sd7, -24'sd7}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint scale(input longint s, input int g);
    return (s * g) >>> $clog2(STEPS);
  endfunction

  // Present one pair on a falling edge, read the result one edge later
  task automatic sendPair(input logic m, input longint l, input longint r);
    @(negedge clk);
    muteN       = m;
    sampleLeft  = W'(l);
    sampleRight = W'(r);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic modelPair(input string req, input logic m, input longint l, input longint r);
    if (!m && expGain > 0) expGain--;
    else if (m && expGain < STEPS) expGain++;
    sendPair(m, l, r);
    chk({req, " valid"}, outValid, 1);
    chk({req, " left"}, outLeft, scale(l, expGain));
    chk({req, " right"}, outRight, scale(r, expGain));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 flag in reset", zeroPullN, 1);
    chk("R1 valid in reset", outValid, 0);
    chk("R1 left in reset", outLeft, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 flag after reset", zeroPullN, 1);
    chk("R1 right after reset", outRight, 0);

    // Table walk: R5 pass-through, R6 and R7 ramp steps
    for (int i = 0; i < 9; i++) begin
      sendPair(VECS[i].m, VECS[i].l, VECS[i].r);
      chk("R10 vec valid", outValid, 1);
      chk("R5/R6/R7 vec left", outLeft, VECS[i].el);
      chk("R5/R6/R7 vec right", outRight, VECS[i].er);
      @(negedge clk);
      chk("R10 vec strobe single", outValid, 0);
    end

    // R6 full ramp to silence and floor
    expGain = STEPS;
    for (int i = 0; i < STEPS + 2; i++) modelPair("R6", 1'b0, 1234, -4321);
    chk("R6 floor left", outLeft, 0);

    // R8 mute released with no valid pairs: gain must not move
    @(negedge clk);
    muteN = 1'b1;
    repeat (20) @(negedge clk);
    modelPair("R8", 1'b1, 3200, -3200);
    chk("R8 single step", outLeft, 200);

    // R7 ramp back to unity
    for (int i = 0; i < STEPS; i++) modelPair("R7", 1'b1, 5000, -77);
    chk("R7 unity", outLeft, 5000);

    // R2 zero run onset
    sendPair(1'b1, 0, 0);           // edge 1 taken
    repeat (LIMIT - 2) @(negedge clk);
    chk("R2 flag at limit-1", zeroPullN, 1);
    @(negedge clk);
    chk("R2 flag at limit", zeroPullN, 0);

    // R4 saturation
    repeat (1000) @(negedge clk);
    chk("R4 flag held", zeroPullN, 0);
    sendPair(1'b1, 0, 0);
    chk("R4 flag held after zero pair", zeroPullN, 0);

    // R3 non-zero on right channel only releases at once
    sendPair(1'b1, 0, 1);
    chk("R3 release right", zeroPullN, 1);
    sendPair(1'b1, 0, 0);
    repeat (50) @(negedge clk);
    sendPair(1'b1, -1, 0);
    chk("R3 release left", zeroPullN, 1);

    // R9 reset mid-run clears the counter
    sendPair(1'b1, 0, 0);
    repeat (100) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R9 flag in reset", zeroPullN, 1);
    rstN = 1'b1;
    sendPair(1'b1, 0, 0);
    repeat (LIMIT - 2) @(negedge clk);
    chk("R9 no early flag", zeroPullN, 1);
    @(negedge clk);
    chk("R9 flag after full run", zeroPullN, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule